// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Engine

This block is a single transmit channel that walks a chain of buffer descriptors kept in a small on-chip descriptor RAM. For each descriptor it fetches packet bytes from an on-chip buffer RAM and streams them out one byte per beat on a valid/ready interface. When a descriptor is done, the engine writes its status word back to hand it to the host. If the chain ends there, it also marks the queue as stopped.

Each descriptor occupies four consecutive 32-bit words. The host builds the chain in the descriptor RAM and gives each descriptor to the engine by setting its ownership flag. It then starts the channel by writing the first descriptor's address into the head register. The host learns that a descriptor is finished by seeing its ownership flag cleared. It acknowledges by writing that descriptor's address into the completion register. If the host appends to a chain after the engine has marked end-of-queue, it restarts the engine with a new head write. A soft-reset bit aborts all activity and clears itself once the engine is quiet.

Top module: `txdma_engine`

## Requirements
- R1: A descriptor at word address D holds the next-descriptor word address at D+0, the buffer byte address at D+1 and the mode word at D+3; the word at D+2 is never read. The engine emits mode[10:0] bytes starting at the buffer byte address. Byte k of buffer word W has byte address 4W+k and sits in bits [8k+7:8k].
- R2: In the mode word, bit 31 is start-of-packet, bit 30 end-of-packet, bit 29 ownership (1 = engine owns) and bit 28 end-of-queue. After its last byte, the engine rewrites the mode word with bit 29 cleared and every other bit kept, except bit 28 as given in R3.
- R3: If the finished descriptor's next word is zero, the write-back also sets bit 28, the engine goes idle and the head register reads 0. Otherwise bit 28 is left as it was and the engine moves on to the next descriptor.
- R4: The host registers are word-selected by a 2-bit address: 0 control, 1 head, 2 completion, 3 soft reset. A nonzero head write while idle starts the engine at that address. A head write while busy, or a zero head write, has no effect. While busy, the head register reads the address of the descriptor in progress.
- R5: If a fetched descriptor has bit 29 clear, the engine stops at once. It emits no bytes, leaves that descriptor unchanged and goes idle, with the head register reading 0.
- R6: No new descriptor is begun while control bit 0 is clear. A pending start proceeds once the bit is set.
- R7: Writing 1 to bit 0 of the soft-reset register aborts any transfer and drops the stream valid. Head and completion registers become 0, and the bit reads 1 until that is done, then clears by itself within three cycles.
- R8: A descriptor with bit 30 set and a length below 60 is padded with zero bytes to 60 bytes. A descriptor without bit 30 is never padded, and a length of 0 then emits nothing.
- R9: The last-byte marker is high only on the final byte of a descriptor with bit 30 set.
- R10: While valid is high and ready is low, valid, data and the last-byte marker hold steady.
- R11: The completion register stores and reads back whatever 32-bit value the host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register select |
| reg_wdata | input | 32 | Host register write data |
| reg_rdata | output | 32 | Host register read data (combinational) |
| desc_host_we | input | 1 | Host write to descriptor RAM |
| desc_host_addr | input | DESC_AW | Host descriptor RAM word address |
| desc_host_wdata | input | 32 | Host descriptor RAM write data |
| desc_host_rdata | output | 32 | Host descriptor RAM read data, one cycle after the address |
| buf_host_we | input | 1 | Host write to buffer RAM |
| buf_host_addr | input | BUF_AW | Host buffer RAM word address |
| buf_host_wdata | input | 32 | Host buffer RAM write data |
| buf_host_rdata | output | 32 | Host buffer RAM read data, one cycle after the address |
| tx_data | output | 8 | Stream byte |
| tx_valid | output | 1 | Stream byte valid |
| tx_last | output | 1 | Final byte of an end-of-packet descriptor |
| tx_ready | input | 1 | Stream sink ready |

## Verification
The bench targets these cases:

- **Unaligned buffer addresses.** A wrong lane or word advance would scramble or repeat bytes.
- **Short end-of-packet descriptors next to short non-end-of-packet ones.** These show whether padding is applied only where it belongs.
- **A descriptor left owned by the host in the middle of a chain.** An engine that ignored ownership would stream stale data or overwrite the host's descriptor.
- **Head writes in awkward states.** One arrives while the channel is disabled, one while busy, and one re-arms a chain already marked end-of-queue. A wrong gate would start twice, lose the start, or jump chains.
- **Soft reset in the middle of a packet.** It must silence the stream and zero the pointers.
- **Random stalls on ready.** These probe the hold rule.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    localparam int MODE_SOP_BIT = 31;
    localparam int MODE_EOP_BIT = 30;
    localparam int MODE_OWN_BIT = 29;
    localparam int MODE_EOQ_BIT = 28;
    localparam int LEN_W        = 11;
    localparam int MIN_FRAME    = 60;

    localparam int WORD_NEXT = 0;
    localparam int WORD_BUF  = 1;
    localparam int WORD_MODE = 3;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_HEAD = 2'd1,
        SEL_COMP = 2'd2,
        SEL_SRST = 2'd3
    } reg_sel_e;

    typedef enum logic [2:0] {
        W_IDLE,
        W_REQ_NEXT,
        W_REQ_BUF,
        W_REQ_MODE,
        W_EVAL,
        W_FETCH,
        W_SEND,
        W_WBACK
    } walk_state_e;

    // Bytes a descriptor emits, padding end-of-packet frames to the minimum.
    function automatic logic [LEN_W-1:0] frame_total(input logic [31:0] mode);
        logic [LEN_W-1:0] len;
        len = mode[LEN_W-1:0];
        if (mode[MODE_EOP_BIT] && (len < LEN_W'(MIN_FRAME)))
            return LEN_W'(MIN_FRAME);
        return len;
    endfunction

    // Status word returned to the host once a descriptor is done.
    function automatic logic [31:0] retire_mode(input logic [31:0] mode, input logic chain_end);
        logic [31:0] m;
        m = mode;
        m[MODE_OWN_BIT] = 1'b0;
        if (chain_end)
            m[MODE_EOQ_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/txdma_dpram.sv
module txdma_dpram #(
    parameter int WORDS = 64,
    parameter int DW    = 32
) (
    input  logic                     clk,
    input  logic                     a_we,
    input  logic [$clog2(WORDS)-1:0] a_addr,
    input  logic [DW-1:0]            a_wdata,
    output logic [DW-1:0]            a_rdata,
    input  logic                     b_we,
    input  logic [$clog2(WORDS)-1:0] b_addr,
    input  logic [DW-1:0]            b_wdata,
    output logic [DW-1:0]            b_rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (a_we)
            mem[a_addr] <= a_wdata;
        if (b_we)
            mem[b_addr] <= b_wdata;
        a_rdata <= mem[a_addr];
        b_rdata <= mem[b_addr];
    end
endmodule

// File: rtl/txdma_hostregs.sv
module txdma_hostregs
    import txdma_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             eng_busy,
    input  logic [PTR_W-1:0] eng_cur,
    output logic             chan_en,
    output logic             start,
    output logic [PTR_W-1:0] start_ptr,
    output logic             abort
);
    logic        srst_pend;
    logic [31:0] comp_q;
    reg_sel_e    sel;

    assign sel       = reg_sel_e'(addr);
    assign abort     = srst_pend;
    assign start_ptr = wdata[PTR_W-1:0];
    assign start     = wr_en && (sel == SEL_HEAD) && (wdata[PTR_W-1:0] != '0)
                       && !eng_busy && !srst_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_en   <= 1'b0;
            comp_q    <= '0;
            srst_pend <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_CTRL)
                chan_en <= wdata[0];
            if (wr_en && sel == SEL_SRST && wdata[0]) begin
                srst_pend <= 1'b1;
            end else if (srst_pend && !eng_busy) begin
                srst_pend <= 1'b0;
                comp_q    <= '0;
            end
            if (wr_en && sel == SEL_COMP && !srst_pend)
                comp_q <= wdata;
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = {31'd0, chan_en};
            SEL_HEAD: rdata = 32'(eng_cur);
            SEL_COMP: rdata = comp_q;
            SEL_SRST: rdata = {31'd0, srst_pend};
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/txdma_walker.sv
module txdma_walker
    import txdma_pkg::*;
#(
    parameter int DA_W = 6,
    parameter int BA_W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chan_en,
    input  logic            start,
    input  logic [DA_W-1:0] start_ptr,
    input  logic            abort,
    output logic            d_we,
    output logic [DA_W-1:0] d_addr,
    output logic [31:0]     d_wdata,
    input  logic [31:0]     d_rdata,
    output logic [BA_W-1:0] b_addr,
    input  logic [31:0]     b_rdata,
    output logic [7:0]      tx_data,
    output logic            tx_valid,
    output logic            tx_last,
    input  logic            tx_ready,
    output logic            busy,
    output logic [DA_W-1:0] cur
);
    localparam int BYTE_W = BA_W + 2;

    walk_state_e       state;
    logic [DA_W-1:0]   nxt;
    logic              chain_end;
    logic [BYTE_W-1:0] base;
    logic [31:0]       mode;
    logic [LEN_W-1:0]  total;
    logic [LEN_W-1:0]  cnt;
    logic [BYTE_W-1:0] byte_addr;
    logic [31:0]       lane_word;
    logic              final_byte;

    assign busy       = (state != W_IDLE);
    assign byte_addr  = base + BYTE_W'(cnt);
    assign b_addr     = byte_addr[BYTE_W-1:2];
    assign lane_word  = b_rdata >> {byte_addr[1:0], 3'b000};
    assign final_byte = (cnt == total - LEN_W'(1));

    assign tx_valid = (state == W_SEND);
    assign tx_data  = (cnt < mode[LEN_W-1:0]) ? lane_word[7:0] : 8'h00;
    assign tx_last  = tx_valid && final_byte && mode[MODE_EOP_BIT];

    assign d_we    = (state == W_WBACK);
    assign d_wdata = retire_mode(mode, chain_end);

    always_comb begin
        unique case (state)
            W_REQ_BUF:           d_addr = cur + DA_W'(WORD_BUF);
            W_REQ_MODE, W_WBACK: d_addr = cur + DA_W'(WORD_MODE);
            default:             d_addr = cur + DA_W'(WORD_NEXT);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= W_IDLE;
            cur       <= '0;
            nxt       <= '0;
            chain_end <= 1'b0;
            base      <= '0;
            mode      <= '0;
            total     <= '0;
            cnt       <= '0;
        end else if (abort) begin
            state <= W_IDLE;
            cur   <= '0;
        end else begin
            unique case (state)
                W_IDLE: begin
                    if (start) begin
                        cur   <= start_ptr;
                        state <= W_REQ_NEXT;
                    end
                end
                W_REQ_NEXT: begin
                    if (chan_en)
                        state <= W_REQ_BUF;
                end
                W_REQ_BUF: begin
                    nxt       <= d_rdata[DA_W-1:0];
                    chain_end <= (d_rdata == 32'd0);
                    state     <= W_REQ_MODE;
                end
                W_REQ_MODE: begin
                    base  <= d_rdata[BYTE_W-1:0];
                    state <= W_EVAL;
                end
                W_EVAL: begin
                    mode  <= d_rdata;
                    total <= frame_total(d_rdata);
                    cnt   <= '0;
                    if (!d_rdata[MODE_OWN_BIT]) begin
                        state <= W_IDLE;
                        cur   <= '0;
                    end else if (frame_total(d_rdata) == '0) begin
                        state <= W_WBACK;
                    end else begin
                        state <= W_FETCH;
                    end
                end
                W_FETCH: begin
                    state <= W_SEND;
                end
                W_SEND: begin
                    if (tx_ready) begin
                        if (final_byte) begin
                            state <= W_WBACK;
                        end else begin
                            cnt <= cnt + LEN_W'(1);
                            if (byte_addr[1:0] == 2'b11)
                                state <= W_FETCH;
                        end
                    end
                end
                W_WBACK: begin
                    if (chain_end) begin
                        state <= W_IDLE;
                        cur   <= '0;
                    end else begin
                        cur   <= nxt;
                        state <= W_REQ_NEXT;
                    end
                end
                default: state <= W_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txdma_engine.sv
module txdma_engine
    import txdma_pkg::*;
#(
    parameter int DESC_WORDS = 64,
    parameter int BUF_WORDS  = 256,
    localparam int DESC_AW   = $clog2(DESC_WORDS),
    localparam int BUF_AW    = $clog2(BUF_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr_en,
    input  logic [1:0]         reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic               desc_host_we,
    input  logic [DESC_AW-1:0] desc_host_addr,
    input  logic [31:0]        desc_host_wdata,
    output logic [31:0]        desc_host_rdata,
    input  logic               buf_host_we,
    input  logic [BUF_AW-1:0]  buf_host_addr,
    input  logic [31:0]        buf_host_wdata,
    output logic [31:0]        buf_host_rdata,
    output logic [7:0]         tx_data,
    output logic               tx_valid,
    output logic               tx_last,
    input  logic               tx_ready
);
    logic               chan_en;
    logic               start;
    logic [DESC_AW-1:0] start_ptr;
    logic               abort;
    logic               eng_busy;
    logic [DESC_AW-1:0] eng_cur;
    logic               d_we;
    logic [DESC_AW-1:0] d_addr;
    logic [31:0]        d_wdata;
    logic [31:0]        d_rdata;
    logic [BUF_AW-1:0]  b_addr;
    logic [31:0]        b_rdata;

    txdma_hostregs #(.PTR_W(DESC_AW)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .eng_busy  (eng_busy),
        .eng_cur   (eng_cur),
        .chan_en   (chan_en),
        .start     (start),
        .start_ptr (start_ptr),
        .abort     (abort)
    );

    txdma_walker #(.DA_W(DESC_AW), .BA_W(BUF_AW)) i_walk (
        .clk       (clk),
        .rst       (rst),
        .chan_en   (chan_en),
        .start     (start),
        .start_ptr (start_ptr),
        .abort     (abort),
        .d_we      (d_we),
        .d_addr    (d_addr),
        .d_wdata   (d_wdata),
        .d_rdata   (d_rdata),
        .b_addr    (b_addr),
        .b_rdata   (b_rdata),
        .tx_data   (tx_data),
        .tx_valid  (tx_valid),
        .tx_last   (tx_last),
        .tx_ready  (tx_ready),
        .busy      (eng_busy),
        .cur       (eng_cur)
    );

    txdma_dpram #(.WORDS(DESC_WORDS), .DW(32)) i_desc_ram (
        .clk     (clk),
        .a_we    (d_we),
        .a_addr  (d_addr),
        .a_wdata (d_wdata),
        .a_rdata (d_rdata),
        .b_we    (desc_host_we),
        .b_addr  (desc_host_addr),
        .b_wdata (desc_host_wdata),
        .b_rdata (desc_host_rdata)
    );

    txdma_dpram #(.WORDS(BUF_WORDS), .DW(32)) i_buf_ram (
        .clk     (clk),
        .a_we    (1'b0),
        .a_addr  (b_addr),
        .a_wdata (32'd0),
        .a_rdata (b_rdata),
        .b_we    (buf_host_we),
        .b_addr  (buf_host_addr),
        .b_wdata (buf_host_wdata),
        .b_rdata (buf_host_rdata)
    );
endmodule

// File: rtl/txdma_checker.sv
module txdma_checker #(
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             reg_wr_en,
    input logic [1:0]       reg_addr,
    input logic             eng_busy,
    input logic [PTR_W-1:0] eng_cur,
    input logic             abort
);
    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    assert_last_beat_R9: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        abort |=> !tx_valid);

    assert_srst_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(abort) |-> (!eng_busy && eng_cur == '0));

    assert_start_cause_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(eng_busy) |-> ($past(reg_wr_en) && $past(reg_addr) == 2'd1));
endmodule

bind txdma_engine txdma_checker #(.PTR_W(DESC_AW)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .eng_busy  (eng_busy),
    .eng_cur   (eng_cur),
    .abort     (abort)
);

// File: tb/test_txdma_engine.sv
module test_txdma_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NBYTES     = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        desc_host_we = 1'b0;
    logic [5:0]  desc_host_addr = '0;
    logic [31:0] desc_host_wdata = '0;
    logic [31:0] desc_host_rdata;
    logic        buf_host_we = 1'b0;
    logic [7:0]  buf_host_addr = '0;
    logic [31:0] buf_host_wdata = '0;
    logic [31:0] buf_host_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b0;

    txdma_engine i_txdma_engine (
        .clk(clk), .rst(rst),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .desc_host_we(desc_host_we), .desc_host_addr(desc_host_addr),
        .desc_host_wdata(desc_host_wdata), .desc_host_rdata(desc_host_rdata),
        .buf_host_we(buf_host_we), .buf_host_addr(buf_host_addr),
        .buf_host_wdata(buf_host_wdata), .buf_host_rdata(buf_host_rdata),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    logic [7:0]  bufimg [NBYTES];
    logic [7:0]  exp_data [4096];
    logic        exp_last [4096];
    int          exp_n = 0;
    logic [7:0]  got_data [4096];
    logic        got_last [4096];
    int          got_n = 0;
    logic [31:0] dmode [16];
    int          dnext [16];
    int          dbase [16];
    int          ready_mode = 1;
    logic        hold_pend = 1'b0;
    logic [7:0]  hold_data;
    logic        hold_last;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Stream sink: picks ready, records beats, checks the hold rule.
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog all-requirements actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
        if (!rst) begin
            if (hold_pend)
                chk(tx_valid && tx_data == hold_data && tx_last == hold_last,
                    "R10", "stall hold", {23'd0, tx_valid, tx_data}, {24'd1, hold_data});
            if (ready_mode == 1)      tx_ready = 1'b1;
            else if (ready_mode == 2) tx_ready = 1'b0;
            else                      tx_ready = ($urandom % 4) != 0;
            if (tx_valid && tx_ready && got_n < 4096) begin
                got_data[got_n] = tx_data;
                got_last[got_n] = tx_last;
                got_n++;
            end
            hold_pend = tx_valid && !tx_ready;
            hold_data = tx_data;
            hold_last = tx_last;
        end
    end

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic desc_wr(input int a, input logic [31:0] d);
        @(negedge clk);
        desc_host_we = 1'b1; desc_host_addr = 6'(a); desc_host_wdata = d;
        @(negedge clk);
        desc_host_we = 1'b0;
    endtask

    task automatic desc_rd(input int a, output logic [31:0] v);
        @(negedge clk);
        desc_host_addr = 6'(a);
        @(negedge clk);
        v = desc_host_rdata;
    endtask

    task automatic buf_load();
        for (int w = 0; w < NBYTES/4; w++) begin
            @(negedge clk);
            buf_host_we = 1'b1; buf_host_addr = 8'(w);
            buf_host_wdata = {bufimg[4*w+3], bufimg[4*w+2], bufimg[4*w+1], bufimg[4*w]};
        end
        @(negedge clk);
        buf_host_we = 1'b0;
    endtask

    task automatic rand_image();
        for (int i = 0; i < NBYTES; i++) bufimg[i] = 8'($urandom);
    endtask

    task automatic mk_desc(input int slot, input int nslot, input int base, input int len,
                           input bit eop, input bit own);
        logic [31:0] m;
        m = {1'b1, eop, own, 1'b0, 17'd0, 11'(len)};
        dmode[slot] = m; dnext[slot] = nslot; dbase[slot] = base;
        desc_wr(slot*4 + 0, 32'(nslot*4));
        desc_wr(slot*4 + 1, 32'(base));
        desc_wr(slot*4 + 2, 32'(len));
        desc_wr(slot*4 + 3, m);
    endtask

    task automatic expect_slot(input int slot);
        int len, tot;
        bit eop;
        len = int'(dmode[slot][10:0]);
        eop = dmode[slot][30];
        tot = (eop && len < 60) ? 60 : len;
        for (int k = 0; k < tot; k++) begin
            exp_data[exp_n] = (k < len) ? bufimg[(dbase[slot] + k) % NBYTES] : 8'h00;
            exp_last[exp_n] = eop && (k == tot - 1);
            exp_n++;
        end
    endtask

    function automatic logic [31:0] retired(input int slot);
        logic [31:0] m;
        m = dmode[slot];
        m[29] = 1'b0;
        if (dnext[slot] == 0) m[28] = 1'b1;
        return m;
    endfunction

    task automatic clear_stream();
        got_n = 0; exp_n = 0;
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n;
        n = 0;
        reg_rd(1, v);
        while (v != 0 && n < 20000) begin
            @(negedge clk);
            reg_rd(1, v);
            n++;
        end
        chk(v == 0, req, "engine returns idle, head reads zero", v, 0);
    endtask

    task automatic cmp_stream(input string req);
        int bad;
        bad = 0;
        chk(got_n == exp_n, req, "byte count", 32'(got_n), 32'(exp_n));
        for (int i = 0; i < got_n && i < exp_n; i++) begin
            if (got_data[i] !== exp_data[i] || got_last[i] !== exp_last[i]) begin
                if (bad == 0)
                    chk(1'b0, req, $sformatf("byte %0d data/last", i),
                        {23'd0, got_last[i], got_data[i]}, {23'd0, exp_last[i], exp_data[i]});
                bad++;
            end
        end
        if (bad == 0) chk(1'b1, req, "stream content", 0, 0);
    endtask

    task automatic chk_mode(input int slot, input logic [31:0] e, input string req);
        logic [31:0] v;
        desc_rd(slot*4 + 3, v);
        chk(v == e, req, $sformatf("mode word slot %0d", slot), v, e);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        reg_rd(0, v); chk(v == 0, "R6", "reset control", v, 0);
        reg_rd(1, v); chk(v == 0, "R4", "reset head", v, 0);
        reg_rd(2, v); chk(v == 0, "R11", "reset completion", v, 0);
        reg_rd(3, v); chk(v == 0, "R7", "reset soft-reset bit", v, 0);
        chk(tx_valid == 0, "R10", "reset valid", {31'd0, tx_valid}, 0);

        rand_image();
        buf_load();
        reg_wr(0, 1);

        // R1 R2 R3 R9: single packet from an unaligned buffer
        clear_stream();
        mk_desc(1, 0, 3, 100, 1, 1);
        expect_slot(1);
        ready_mode = 0;
        reg_wr(1, 4);
        wait_idle("R3");
        cmp_stream("R1");
        chk_mode(1, retired(1), "R2");

        // R8 R9 R3: chain with short EOP, short non-EOP, zero-length non-EOP
        clear_stream();
        mk_desc(2, 3, 10, 20, 0, 1);
        mk_desc(3, 4, 201, 0, 0, 1);
        mk_desc(4, 5, 402, 7, 1, 1);
        mk_desc(5, 0, 517, 61, 1, 1);
        for (int s = 2; s <= 5; s++) expect_slot(s);
        reg_wr(1, 8);
        wait_idle("R3");
        cmp_stream("R8");
        for (int s = 2; s <= 5; s++) chk_mode(s, retired(s), "R3");

        // R5: host-owned descriptor in the middle of a chain
        clear_stream();
        mk_desc(6, 7, 40, 70, 1, 1);
        mk_desc(7, 8, 90, 70, 1, 0);
        mk_desc(8, 0, 190, 70, 1, 1);
        expect_slot(6);
        reg_wr(1, 24);
        wait_idle("R5");
        cmp_stream("R5");
        chk_mode(6, retired(6), "R5");
        chk_mode(7, dmode[7], "R5");
        chk_mode(8, dmode[8], "R5");

        // R6: channel disabled holds a start pending
        clear_stream();
        reg_wr(0, 0);
        mk_desc(9, 0, 300, 64, 1, 1);
        expect_slot(9);
        reg_wr(1, 36);
        repeat (20) @(negedge clk);
        chk(got_n == 0, "R6", "no bytes while disabled", 32'(got_n), 0);
        reg_rd(1, v); chk(v == 36, "R6", "start pending while disabled", v, 36);
        reg_wr(0, 1);
        wait_idle("R6");
        cmp_stream("R6");

        // R4: head write while busy is ignored, head shows current descriptor
        clear_stream();
        ready_mode = 2;
        mk_desc(10, 0, 600, 80, 1, 1);
        mk_desc(11, 0, 700, 80, 1, 1);
        expect_slot(10);
        reg_wr(1, 40);
        repeat (10) @(negedge clk);
        reg_rd(1, v); chk(v == 40, "R4", "head while busy", v, 40);
        reg_wr(1, 44);
        reg_wr(1, 0);
        ready_mode = 0;
        wait_idle("R4");
        cmp_stream("R4");
        chk_mode(11, dmode[11], "R4");

        // R11: completion register readback
        reg_wr(2, 32'hA5C3_0028);
        reg_rd(2, v); chk(v == 32'hA5C3_0028, "R11", "completion readback", v, 32'hA5C3_0028);

        // R3 R4: re-arm after end-of-queue
        clear_stream();
        mk_desc(12, 0, 800, 30, 1, 1);
        expect_slot(12);
        reg_wr(1, 48);
        wait_idle("R3");
        chk_mode(12, retired(12), "R3");
        mk_desc(13, 0, 850, 90, 1, 1);
        desc_wr(48, 32'd52);
        expect_slot(13);
        reg_wr(1, 52);
        wait_idle("R4");
        cmp_stream("R4");

        // R7: soft reset in the middle of a packet
        clear_stream();
        ready_mode = 1;
        mk_desc(14, 0, 100, 200, 1, 1);
        reg_wr(1, 56);
        repeat (15) @(negedge clk);
        reg_wr(3, 1);
        reg_rd(3, v); chk(v == 1, "R7", "soft-reset bit set while in progress", v, 1);
        repeat (3) @(negedge clk);
        reg_rd(3, v); chk(v == 0, "R7", "soft-reset bit self-clears", v, 0);
        reg_rd(1, v); chk(v == 0, "R7", "head zeroed", v, 0);
        reg_rd(2, v); chk(v == 0, "R7", "completion zeroed", v, 0);
        chk(tx_valid == 0, "R7", "stream quiet", {31'd0, tx_valid}, 0);
        chk(got_n > 0 && got_n < 200, "R7", "aborted mid packet", 32'(got_n), 100);
        begin
            int n0;
            n0 = got_n;
            repeat (10) @(negedge clk);
            chk(got_n == n0, "R7", "no bytes after abort", 32'(got_n), 32'(n0));
        end
        chk_mode(14, dmode[14], "R7");

        // Random chains with random stalls
        ready_mode = 0;
        for (int it = 0; it < 25; it++) begin
            int n, stop_at;
            rand_image();
            buf_load();
            clear_stream();
            n = 1 + int'($urandom % 4);
            stop_at = ($urandom % 3 == 0) ? int'($urandom % n) : n;
            for (int i = 0; i < n; i++) begin
                mk_desc(i + 1, (i == n - 1) ? 0 : i + 2, int'($urandom % 760), int'($urandom % 201),
                        (i == n - 1) || ($urandom % 2 == 1), i != stop_at);
            end
            for (int i = 0; i < n && i < stop_at; i++) expect_slot(i + 1);
            reg_wr(1, 4);
            wait_idle("R3");
            cmp_stream("R1");
            for (int i = 0; i < n; i++)
                chk_mode(i + 1, (i < stop_at) ? retired(i + 1) : dmode[i + 1], "R2");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule